// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a processor into its exception handler. The request carries a handler vector and a faulting effective address. It arrives alongside the current program counter, a flag saying the faulting instruction sat in a branch delay slot, and the live status word. In the cycle a request is taken, the block commits all of its state updates together. It writes the return address, the faulting address and the untouched status word into three shadow registers. It also publishes a rewritten status word and redirects fetch to the vector.

Taking a request freezes the pipeline for a fixed number of cycles, seven by default. A one-cycle completion pulse marks the end of the freeze. No further request is taken while the freeze lasts. If exception recognition is already switched off in the incoming status word, trapping is unsafe. In that case the block saves nothing and raises a sticky fatal-halt flag.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset `req_ready` is high. A request is taken on a rising edge where `req_valid` and `req_ready` are both high.
- R2: If bit 1 (exception enable) of `cur_sr` is 0 when a request is taken, `halt` rises the next cycle and stays high until reset. No shadow register, status output or fetch output changes, `stall` stays low and `req_ready` goes low.
- R3: The cycle after a request is taken, `epc` holds `cur_pc` minus 4 when `in_dslot` is 1, or `cur_pc` unchanged when it is 0, with bits 1:0 cleared after the subtraction.
- R4: The cycle after a request is taken, `eear` equals the `req_ea` that came with it.
- R5: The cycle after a request is taken, `esr` equals `cur_sr` exactly as it was presented.
- R6: The cycle after a request is taken, `sr_out` equals `cur_sr` with bit 6 (data translation), bit 5 (instruction translation) and bit 1 (exception enable) cleared and bit 0 (supervisor) set. All other bits are kept, and `sr_load` pulses high for that single cycle.
- R7: The cycle after a request is taken, `fetch_pc` equals `req_vector`, `fetch_npc` equals `req_vector + 4`, and `redirect` pulses high for that single cycle.
- R8: `stall` is high for exactly 7 consecutive cycles. The first of them is the cycle after the request is taken.
- R9: `done` is high for exactly one cycle, the first cycle in which `stall` is low again. `req_ready` is high in that cycle.
- R10: `req_ready` is low while `stall` is high. A request presented then is not taken: the shadow registers keep their values and the freeze length is unchanged.
- R11: Reset clears every shadow register, `sr_out`, `fetch_pc`, `fetch_npc`, `stall`, `done`, `halt`, `redirect` and `sr_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Block can take a request |
| req_vector | input | 32 | Handler vector address |
| req_ea | input | 32 | Faulting effective address |
| cur_pc | input | 32 | PC of the faulting instruction |
| in_dslot | input | 1 | Faulting instruction was in a delay slot |
| cur_sr | input | 32 | Live status word |
| epc | output | 32 | Saved return PC |
| eear | output | 32 | Saved effective address |
| esr | output | 32 | Saved status word |
| sr_out | output | 32 | Rewritten status word |
| sr_load | output | 1 | One-cycle pulse: load `sr_out` |
| fetch_pc | output | 32 | Redirected fetch PC |
| fetch_npc | output | 32 | Redirected next PC |
| redirect | output | 1 | One-cycle pulse: apply fetch redirect |
| stall | output | 1 | Pipeline freeze |
| done | output | 1 | One-cycle pulse at end of freeze |
| halt | output | 1 | Sticky fatal halt |

## Verification
Every saved register, the status rewrite and the fetch redirect are due one cycle after the accepting edge. The bench drives on the falling edge and checks all of them at the next falling edge. It then samples `stall` at each of the following falling edges: it must be high at the first seven and low at the eighth, where `done` must be high. The stray request is presented mid-freeze and withdrawn one cycle later, so it can only show up as a changed shadow register at the end of the freeze. The halt case is checked one cycle after its edge and again two cycles later.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   // Mask of the status bits that are cleared on exception entry.
   function automatic logic [63:0] clr_mask(input int unsigned exr_b,
                                            input int unsigned immu_b,
                                            input int unsigned dmmu_b);
      logic [63:0] m;
      m = '0;
      m[exr_b]  = 1'b1;
      m[immu_b] = 1'b1;
      m[dmmu_b] = 1'b1;
      return m;
   endfunction

   // Mask of the status bits that are set on exception entry.
   function automatic logic [63:0] set_mask(input int unsigned supv_b);
      logic [63:0] m;
      m = '0;
      m[supv_b] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/exc_pc_adjust.sv
module exc_pc_adjust #(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned INSN_BYTES   = 4,
   parameter bit          DSLOT_ADJUST = 1'b1
) (
   input  logic [XLEN-1:0] pc_in,
   input  logic            dslot,
   input  logic [XLEN-1:0] vector,
   output logic [XLEN-1:0] pc_save,
   output logic [XLEN-1:0] npc
);
   localparam int unsigned ALIGN_BITS = $clog2(INSN_BYTES);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   logic [XLEN-1:0] pc_back;

   generate
      if (DSLOT_ADJUST) begin : g_adj
         assign pc_back = dslot ? (pc_in - STEP) : pc_in;
      end else begin : g_noadj
         logic unused_dslot;
         assign unused_dslot = dslot;
         assign pc_back = pc_in;
      end
   endgenerate

   always_comb begin
      pc_save = pc_back;
      pc_save[ALIGN_BITS-1:0] = '0;
   end

   assign npc = vector + STEP;
endmodule

// File: rtl/exc_sr_rewrite.sv
module exc_sr_rewrite
   import exc_entry_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned SUPV_BIT = 0,
   parameter int unsigned EXR_BIT  = 1,
   parameter int unsigned IMMU_BIT = 5,
   parameter int unsigned DMMU_BIT = 6
) (
   input  logic [XLEN-1:0] sr_in,
   output logic [XLEN-1:0] sr_out,
   output logic            exr_on
);
   localparam logic [63:0] CLR64 = clr_mask(EXR_BIT, IMMU_BIT, DMMU_BIT);
   localparam logic [63:0] SET64 = set_mask(SUPV_BIT);

   generate
      for (genvar b = 0; b < XLEN; b++) begin : g_bit
         if (SET64[b]) begin : g_set
            assign sr_out[b] = 1'b1;
         end else if (CLR64[b]) begin : g_clr
            assign sr_out[b] = 1'b0;
         end else begin : g_keep
            assign sr_out[b] = sr_in[b];
         end
      end
   endgenerate

   assign exr_on = sr_in[EXR_BIT];
endmodule

// File: rtl/exc_stall_timer.sv
module exc_stall_timer #(
   parameter int unsigned STALL_CYCLES = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic stall,
   output logic done
);
   localparam int unsigned CNT_W = $clog2(STALL_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(STALL_CYCLES);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         if (start)
            cnt_q <= LOAD;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - ONE;
         done_q <= (cnt_q == ONE) && !start;
      end
   end

   assign stall = (cnt_q != '0);
   assign done  = done_q;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned INSN_BYTES   = 4,
   parameter int unsigned STALL_CYCLES = 7,
   parameter int unsigned SUPV_BIT     = 0,
   parameter int unsigned EXR_BIT      = 1,
   parameter int unsigned IMMU_BIT     = 5,
   parameter int unsigned DMMU_BIT     = 6,
   parameter bit          DSLOT_ADJUST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [XLEN-1:0] req_vector,
   input  logic [XLEN-1:0] req_ea,
   input  logic [XLEN-1:0] cur_pc,
   input  logic            in_dslot,
   input  logic [XLEN-1:0] cur_sr,
   output logic [XLEN-1:0] epc,
   output logic [XLEN-1:0] eear,
   output logic [XLEN-1:0] esr,
   output logic [XLEN-1:0] sr_out,
   output logic            sr_load,
   output logic [XLEN-1:0] fetch_pc,
   output logic [XLEN-1:0] fetch_npc,
   output logic            redirect,
   output logic            stall,
   output logic            done,
   output logic            halt
);
   // Elaboration-time parameter checks
   if (XLEN < 8 || XLEN > 64) begin : g_bad_xlen
      $error("XLEN out of range");
   end
   if (STALL_CYCLES < 1) begin : g_bad_stall
      $error("STALL_CYCLES must be at least 1");
   end
   if (INSN_BYTES < 2 || (INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_bad_insn
      $error("INSN_BYTES must be a power of two >= 2");
   end
   if (SUPV_BIT >= XLEN || EXR_BIT >= XLEN || IMMU_BIT >= XLEN || DMMU_BIT >= XLEN) begin : g_bad_pos
      $error("status bit position beyond XLEN");
   end
   if (SUPV_BIT == EXR_BIT || SUPV_BIT == IMMU_BIT || SUPV_BIT == DMMU_BIT ||
       EXR_BIT == IMMU_BIT || EXR_BIT == DMMU_BIT || IMMU_BIT == DMMU_BIT) begin : g_bad_dup
      $error("status bit positions must be distinct");
   end

   logic [XLEN-1:0] pc_save_w, npc_w, sr_new_w;
   logic            exr_on_w;
   logic            take, enter, abort;
   logic            halt_q, sr_load_q, redirect_q;
   logic [XLEN-1:0] epc_q, eear_q, esr_q, sr_q, fpc_q, fnpc_q;

   exc_pc_adjust #(
      .XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .DSLOT_ADJUST(DSLOT_ADJUST)
   ) u_pc (
      .pc_in(cur_pc), .dslot(in_dslot), .vector(req_vector),
      .pc_save(pc_save_w), .npc(npc_w)
   );

   exc_sr_rewrite #(
      .XLEN(XLEN), .SUPV_BIT(SUPV_BIT), .EXR_BIT(EXR_BIT),
      .IMMU_BIT(IMMU_BIT), .DMMU_BIT(DMMU_BIT)
   ) u_sr (
      .sr_in(cur_sr), .sr_out(sr_new_w), .exr_on(exr_on_w)
   );

   exc_stall_timer #(
      .STALL_CYCLES(STALL_CYCLES)
   ) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(enter), .stall(stall), .done(done)
   );

   assign req_ready = !stall && !halt_q;
   assign take      = req_valid && req_ready;
   assign enter     = take && exr_on_w;
   assign abort     = take && !exr_on_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q      <= '0;
         eear_q     <= '0;
         esr_q      <= '0;
         sr_q       <= '0;
         fpc_q      <= '0;
         fnpc_q     <= '0;
         sr_load_q  <= 1'b0;
         redirect_q <= 1'b0;
         halt_q     <= 1'b0;
      end else begin
         sr_load_q  <= enter;
         redirect_q <= enter;
         if (abort)
            halt_q <= 1'b1;
         if (enter) begin
            epc_q  <= pc_save_w;
            eear_q <= req_ea;
            esr_q  <= cur_sr;
            sr_q   <= sr_new_w;
            fpc_q  <= req_vector;
            fnpc_q <= npc_w;
         end
      end
   end

   assign epc       = epc_q;
   assign eear      = eear_q;
   assign esr       = esr_q;
   assign sr_out    = sr_q;
   assign sr_load   = sr_load_q;
   assign fetch_pc  = fpc_q;
   assign fetch_npc = fnpc_q;
   assign redirect  = redirect_q;
   assign halt      = halt_q;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned STALL_CYCLES = 7,
   parameter int unsigned EXR_BIT      = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [XLEN-1:0] req_ea,
   input logic [XLEN-1:0] cur_sr,
   input logic [XLEN-1:0] epc,
   input logic [XLEN-1:0] eear,
   input logic [XLEN-1:0] esr,
   input logic            redirect,
   input logic            stall,
   input logic            done,
   input logic            halt
);
   logic        acc, acc_ok;
   logic [31:0] run_len;

   assign acc    = req_valid && req_ready;
   assign acc_ok = acc && cur_sr[EXR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)     run_len <= '0;
      else if (stall) run_len <= run_len + 32'd1;
      else            run_len <= '0;
   end

   assert_halt_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt);
   assert_halt_nosave_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !cur_sr[EXR_BIT]) |=> ($stable(epc) && !stall && !redirect));
   assert_epc_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok |=> (epc[1:0] == 2'b00));
   assert_eear_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok |=> (eear == $past(req_ea)));
   assert_esr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok |=> (esr == $past(cur_sr)));
   assert_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok |=> (redirect && stall));
   assert_stall_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> (run_len == STALL_CYCLES));
   assert_done_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> done);
   assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !req_ready);
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
   .XLEN(XLEN), .STALL_CYCLES(STALL_CYCLES), .EXR_BIT(EXR_BIT)
) u_chk (.*);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, in_dslot;
   logic [31:0] req_vector, req_ea, cur_pc, cur_sr;
   logic        req_ready, sr_load, redirect, stall, done, halt;
   logic [31:0] epc, eear, esr, sr_out, fetch_pc, fetch_npc;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   exc_entry_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vector(req_vector), .req_ea(req_ea), .cur_pc(cur_pc),
      .in_dslot(in_dslot), .cur_sr(cur_sr), .epc(epc), .eear(eear), .esr(esr),
      .sr_out(sr_out), .sr_load(sr_load), .fetch_pc(fetch_pc),
      .fetch_npc(fetch_npc), .redirect(redirect), .stall(stall), .done(done),
      .halt(halt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One accepted entry, with optional stray request mid-freeze (R10).
   task automatic entry(input logic [31:0] vec, input logic [31:0] ea,
                        input logic [31:0] pc, input logic ds,
                        input logic [31:0] sr, input bit stray);
      logic [31:0] exp_epc, exp_sr;
      exp_epc = (ds ? pc - 32'd4 : pc) & ~32'd3;
      exp_sr  = (sr & ~32'h0000_0062) | 32'h1;
      @(negedge clk);
      chk("R1 ready before", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_vector = vec; req_ea = ea;
      cur_pc = pc; in_dslot = ds; cur_sr = sr;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R3 epc", epc, exp_epc);
      chk("R4 eear", eear, ea);
      chk("R5 esr", esr, sr);
      chk("R6 sr_out", sr_out, exp_sr);
      chk("R6 sr_load", {31'd0, sr_load}, 32'd1);
      chk("R7 fetch_pc", fetch_pc, vec);
      chk("R7 fetch_npc", fetch_npc, vec + 32'd4);
      chk("R7 redirect", {31'd0, redirect}, 32'd1);
      chk("R8 stall first", {31'd0, stall}, 32'd1);
      for (int k = 2; k <= 7; k++) begin
         if (stray && k == 3) begin
            req_valid = 1'b1; req_vector = ~vec; req_ea = ~ea;
            cur_pc = pc + 32'h100; cur_sr = ~sr;
         end
         @(negedge clk);
         req_valid = 1'b0;
         chk("R8 stall held", {31'd0, stall}, 32'd1);
         chk("R10 ready low", {31'd0, req_ready}, 32'd0);
         chk("R7 redirect one-shot", {31'd0, redirect}, 32'd0);
      end
      @(negedge clk);
      chk("R8 stall ends", {31'd0, stall}, 32'd0);
      chk("R9 done", {31'd0, done}, 32'd1);
      chk("R9 ready", {31'd0, req_ready}, 32'd1);
      chk("R10 epc kept", epc, exp_epc);
      chk("R10 eear kept", eear, ea);
      chk("R10 esr kept", esr, sr);
      @(negedge clk);
      chk("R9 done one-shot", {31'd0, done}, 32'd0);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] last_epc, last_eear, last_esr;
      rst_n = 1'b0; req_valid = 1'b0; in_dslot = 1'b0;
      req_vector = '0; req_ea = '0; cur_pc = '0; cur_sr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R11 epc", epc, 32'd0);
      chk("R11 sr_out", sr_out, 32'd0);
      chk("R11 fetch_pc", fetch_pc, 32'd0);
      chk("R11 flags", {26'd0, stall, done, halt, redirect, sr_load, 1'b0}, 32'd0);
      chk("R1 ready reset", {31'd0, req_ready}, 32'd1);

      for (int ds = 0; ds < 2; ds++)
         for (int lo = 0; lo < 4; lo++)
            for (int s = 0; s < 4; s++) begin
               logic [31:0] srp;
               case (s)
                  0: srp = 32'h0000_0002;
                  1: srp = 32'hFFFF_FFFF;
                  2: srp = 32'h8000_0062;
                  default: srp = 32'h1234_5A9E;
               endcase
               entry(32'h0000_0100 * (s + 1) + 32'h1000 * ds,
                     32'hDEAD_0000 + 32'(lo * 16 + s),
                     32'h0000_4000 + 32'(lo) + 32'(s * 8) + 32'(ds * 64),
                     ds[0], srp, (lo == 2));
            end
      entry(32'hFFFF_FFFC, 32'h0, 32'h0000_0002, 1'b1, 32'h2, 1'b0);

      last_epc = epc; last_eear = eear; last_esr = esr;
      @(negedge clk);
      req_valid = 1'b1; cur_sr = 32'hFFFF_FFFD; cur_pc = 32'h8888_0000;
      req_ea = 32'h5555_5555; req_vector = 32'h0000_0700;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 halt", {31'd0, halt}, 32'd1);
      chk("R2 epc", epc, last_epc);
      chk("R2 eear", eear, last_eear);
      chk("R2 esr", esr, last_esr);
      chk("R2 stall", {31'd0, stall}, 32'd0);
      chk("R2 redirect", {31'd0, redirect}, 32'd0);
      chk("R2 ready", {31'd0, req_ready}, 32'd0);
      repeat (2) @(negedge clk);
      chk("R2 halt sticky", {31'd0, halt}, 32'd1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule